// File: doc/BRIEF.md
# Sector CRC-16 Generator

This block computes a 16-bit cyclic redundancy check over one fixed-length sector of 16-bit data words. A producer pulses a start/clear input at the beginning of a sector and then offers words one at a time with a valid strobe whenever the block shows ready. Each word is absorbed least-significant bit first into a reflected CRC register that starts from zero. When the last word of the sector has been absorbed, the block raises a one-cycle done pulse. The CRC output then holds the sector's value until the next clear.

Two implementations are selected by a parameter. The bit-serial variant spends one clock per data bit and lowers ready while it shifts. The parallel variant absorbs a whole word in a single clock and can take a word on every cycle. Both produce identical CRC values for the same word stream.

Top module: `crc16_sector_gen`

## Requirements
- R1: After reset, `crc_o` is 0x0000, `done_o` is low and `ready_o` is high.
- R2: The CRC starts at zero. Each word is processed bit 0 first, through bit 15, one step per bit. In a step, the incoming bit is XORed with the register's bit 0. If that XOR is 1, the register is shifted right by one and then XORed with POLY (default 0xA001). If it is 0, the register is only shifted right. `crc_o` shows the running value after each absorbed word.
- R3: A sector is exactly FRAME_WORDS words (default 32). `done_o` is high for exactly one cycle, in the cycle right after the final word of the sector has been fully absorbed, and at no other time.
- R4: Once a sector is complete, `ready_o` stays low and `crc_o` holds the final value until the next clear. A `word_valid_i` offered in that state changes nothing.
- R5: A high `clear_i` zeroes the CRC and the word count on the next edge and discards any partial sector, including a word that is in the middle of serial shifting. When `clear_i` and `word_valid_i` are high in the same cycle, the word is not absorbed.
- R6: With SERIAL=1, an accepted word keeps `ready_o` low for the next 16 cycles. Its result appears in the cycle after the 16th shift step. A `word_valid_i` while `ready_o` is low is ignored.
- R7: With SERIAL=0, `ready_o` stays high until the sector completes. A word accepted at an edge is reflected in `crc_o` in the following cycle, so words can be accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Start a new sector: zero CRC and word count |
| word_valid_i | input | 1 | A data word is offered this cycle |
| word_i | input | 16 | Data word |
| ready_o | output | 1 | A word offered now will be accepted |
| crc_o | output | 16 | Running / final CRC value |
| done_o | output | 1 | One-cycle pulse after the last word of the sector |

## Verification
The bench builds two copies of the block side by side with the default 32-word sector and 0xA001 polynomial. One copy uses SERIAL=1 and the other uses SERIAL=0, and both are checked against the same software model. The serial copy covers the 16-cycle busy window, words offered during shifting, and a clear that lands mid-shift. The parallel copy covers words on back-to-back cycles and a clear coinciding with a valid word. Both copies cover complete sectors of random and directed words, the single-cycle done pulse, and the frozen result after completion.

// File: rtl/crc16_sector_pkg.sv
// Package: shared widths, the CRC type and the reflected CRC step functions.
// Assumes data words and the CRC register have the same width.
package crc16_sector_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned CRC_W  = 16;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [DATA_W-1:0] word_t;

    // One reflected shift step with one incoming data bit.
    function automatic crc_t crc_bit_step(input crc_t cur, input logic din, input crc_t poly);
        logic fb;
        fb = cur[0] ^ din;
        return (cur >> 1) ^ (fb ? poly : crc_t'(0));
    endfunction

    // A whole word, bit 0 first.
    function automatic crc_t crc_word_step(input crc_t cur, input word_t w, input crc_t poly);
        crc_t acc;
        acc = cur;
        for (int i = 0; i < int'(DATA_W); i++) begin
            acc = crc_bit_step(acc, w[i], poly);
        end
        return acc;
    endfunction
endpackage

// File: rtl/crc16_word_engine.sv
// Word engine: folds one data word into the CRC register.
// SERIAL=1 shifts one bit per clock and reports busy.
// SERIAL=0 folds the whole word in one clock.
// Assumes load_i is only raised when busy_o is low and clear_i is low.
module crc16_word_engine
    import crc16_sector_pkg::*;
#(
    parameter crc_t POLY   = 16'hA001,
    parameter bit   SERIAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  load_i,
    input  word_t word_i,
    output crc_t  crc_o,
    output logic  busy_o,
    output logic  word_done_o
);
    crc_t crc_q;

    generate
        if (SERIAL) begin : g_serial
            localparam int unsigned BITS_W = $clog2(DATA_W + 1);
            word_t             shift_q;
            logic [BITS_W-1:0] left_q;

            // Load a word, then shift one bit per clock until none are left.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    crc_q   <= '0;
                    shift_q <= '0;
                    left_q  <= '0;
                end else if (clear_i) begin
                    crc_q  <= '0;
                    left_q <= '0;
                end else if (load_i) begin
                    shift_q <= word_i;
                    left_q  <= BITS_W'(DATA_W);
                end else if (left_q != '0) begin
                    crc_q   <= crc_bit_step(crc_q, shift_q[0], POLY);
                    shift_q <= shift_q >> 1;
                    left_q  <= left_q - BITS_W'(1);
                end
            end

            assign busy_o      = (left_q != '0);
            assign word_done_o = (left_q == BITS_W'(1));

            // R6: an accepted word makes the engine busy on the next cycle
            a_r6_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
                (load_i && !clear_i) |=> busy_o);
        end else begin : g_parallel
            // Fold a full word per accepted strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    crc_q <= '0;
                end else if (clear_i) begin
                    crc_q <= '0;
                end else if (load_i) begin
                    crc_q <= crc_word_step(crc_q, word_i, POLY);
                end
            end

            assign busy_o      = 1'b0;
            assign word_done_o = load_i;
        end
    endgenerate

    assign crc_o = crc_q;

    // R5: a clear leaves a zero register on the next cycle
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == '0));
    // R4: with no work and no clear the register does not move
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i && !busy_o) |=> $stable(crc_o));
    // R6: no new word arrives while shifting
    a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_i);
endmodule

// File: rtl/crc16_frame_counter.sv
// Frame counter: counts completed words in a sector and pulses done after the last one.
// Assumes word_done_i is never raised once the sector is full.
module crc16_frame_counter #(
    parameter int unsigned FRAME_WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic word_done_i,
    output logic full_o,
    output logic done_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_WORDS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Count absorbed words and flag the final one for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= word_done_i && (cnt_q == CNT_W'(FRAME_WORDS - 1));
            if (word_done_i) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign full_o = (cnt_q == CNT_W'(FRAME_WORDS));
    assign done_o = done_q;

    // R3: the done pulse lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3: done only appears once the sector is complete
    a_r3_done_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> full_o);
    // R4: no word completes after the sector is full
    a_r4_no_word_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !word_done_i);
    // R3: the count never passes the sector length
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_WORDS));
endmodule

// File: rtl/crc16_sector_gen.sv
// Top: sector CRC-16 generator. Accepts words while ready, folds them into a
// reflected CRC that starts at zero, and pulses done after FRAME_WORDS words.
// Assumes the producer holds each word only for the cycle it is accepted.
module crc16_sector_gen
    import crc16_sector_pkg::*;
#(
    parameter int unsigned FRAME_WORDS = 32,
    parameter crc_t        POLY        = 16'hA001,
    parameter bit          SERIAL      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              word_valid_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              ready_o,
    output logic [CRC_W-1:0]  crc_o,
    output logic              done_o
);
    logic busy;
    logic full;
    logic load;
    logic word_done;

    // Accept a word only when idle, the sector is open and no clear is pending.
    always_comb begin
        ready_o = !busy && !full;
        load    = word_valid_i && ready_o && !clear_i;
    end

    crc16_word_engine #(
        .POLY   (POLY),
        .SERIAL (SERIAL)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .load_i      (load),
        .word_i      (word_i),
        .crc_o       (crc_o),
        .busy_o      (busy),
        .word_done_o (word_done)
    );

    crc16_frame_counter #(
        .FRAME_WORDS (FRAME_WORDS)
    ) i_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .word_done_i (word_done),
        .full_o      (full),
        .done_o      (done_o)
    );

    // R4: the result stays frozen after done until a clear
    a_r4_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> $stable(crc_o));
    // R4: nothing is accepted once the sector is complete
    a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear_i) |=> $stable(crc_o));
endmodule

// File: tb/test_crc16_sector_gen.sv
// Bench: a serial and a parallel instance checked against a software CRC model.
module test_crc16_sector_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        valid_s = 1'b0;
    logic        valid_p = 1'b0;
    logic [15:0] word = '0;
    logic        ready_s, ready_p, done_s, done_p;
    logic [15:0] crc_s, crc_p;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] exp_crc = '0;
    int nwords = 0;

    always #4 clk = ~clk;

    crc16_sector_gen #(.FRAME_WORDS(32), .POLY(16'hA001), .SERIAL(1'b1)) i_crc16_sector_gen (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .word_valid_i(valid_s),
        .word_i(word), .ready_o(ready_s), .crc_o(crc_s), .done_o(done_s));

    crc16_sector_gen #(.FRAME_WORDS(32), .POLY(16'hA001), .SERIAL(1'b0)) i_crc16_sector_gen_par (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .word_valid_i(valid_p),
        .word_i(word), .ready_o(ready_p), .crc_o(crc_p), .done_o(done_p));

    function automatic logic [15:0] model(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        logic b;
        r = c;
        for (int i = 0; i < 16; i++) begin
            b = r[0] ^ w[i];
            r = r >> 1;
            if (b) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        exp_crc = '0; nwords = 0;
        chk("R5 serial crc zero after clear", crc_s, 0);
        chk("R5 parallel crc zero after clear", crc_p, 0);
        chk("R5 serial ready after clear", ready_s, 1);
        chk("R5 parallel ready after clear", ready_p, 1);
    endtask

    // Offer one word to both instances; optionally poke the serial one while it is busy.
    task automatic send_both(input logic [15:0] w, input bit intrude);
        int first;
        exp_crc = model(exp_crc, w);
        nwords++;
        @(negedge clk); word = w; valid_s = 1'b1; valid_p = 1'b1;
        @(negedge clk); valid_s = 1'b0; valid_p = 1'b0;
        chk("R2 parallel running crc", crc_p, exp_crc);
        chk("R3 parallel done timing", done_p, (nwords == 32));
        chk("R6 serial ready low after accept", ready_s, 0);
        first = 1;
        if (intrude) begin
            word = ~w; valid_s = 1'b1;
            @(negedge clk); valid_s = 1'b0; word = w;
            first = 2;
        end
        for (int i = first; i <= 15; i++) begin
            if (i == first) @(negedge clk);
            else @(negedge clk);
            chk("R6 serial ready low while shifting", ready_s, 0);
            chk("R3 serial no early done", done_s, 0);
            if (i == 1) chk("R3 parallel done single cycle", done_p, 0);
        end
        @(negedge clk);
        chk("R6 serial crc after 16 steps", crc_s, exp_crc);
        chk("R3 serial done timing", done_s, (nwords == 32));
        chk("R6 serial ready after word", ready_s, (nwords != 32));
        chk("R7 parallel ready until full", ready_p, (nwords != 32));
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 serial crc reset", crc_s, 0);
        chk("R1 parallel crc reset", crc_p, 0);
        chk("R1 serial done reset", done_s, 0);
        chk("R1 parallel done reset", done_p, 0);
        chk("R1 serial ready reset", ready_s, 1);
        chk("R1 parallel ready reset", ready_p, 1);

        // R2/R3: random sector, with a serial intrusion on some words (R6)
        for (int k = 0; k < 32; k++) send_both(16'($urandom), (k % 5 == 2));
        // R4: completed sector ignores further words
        @(negedge clk);
        chk("R3 serial done gone", done_s, 0);
        chk("R4 serial ready low when full", ready_s, 0);
        chk("R4 parallel ready low when full", ready_p, 0);
        word = 16'h5A5A; valid_s = 1'b1; valid_p = 1'b1;
        @(negedge clk); valid_s = 1'b0; valid_p = 1'b0;
        repeat (17) @(negedge clk);
        chk("R4 serial crc held after full", crc_s, exp_crc);
        chk("R4 parallel crc held after full", crc_p, exp_crc);
        chk("R4 serial no second done", done_s, 0);
        chk("R4 parallel no second done", done_p, 0);

        // R5: partial sector discarded, then a directed all-ones sector
        do_clear();
        for (int k = 0; k < 5; k++) send_both(16'($urandom), 1'b0);
        do_clear();
        for (int k = 0; k < 32; k++) send_both(16'hFFFF, 1'b0);

        // R5: clear and valid together; word not absorbed, count stays at zero
        @(negedge clk); clear = 1'b1; valid_s = 1'b1; valid_p = 1'b1; word = 16'h1234;
        @(negedge clk); clear = 1'b0; valid_s = 1'b0; valid_p = 1'b0;
        exp_crc = '0; nwords = 0;
        chk("R5 serial clear beats valid", crc_s, 0);
        chk("R5 parallel clear beats valid", crc_p, 0);
        chk("R5 serial not busy after clear+valid", ready_s, 1);
        for (int k = 0; k < 32; k++) send_both((k == 0) ? 16'h0001 : 16'($urandom), 1'b0);

        // R5: clear during serial shifting
        do_clear();
        @(negedge clk); word = 16'hBEEF; valid_s = 1'b1;
        @(negedge clk); valid_s = 1'b0;
        repeat (4) @(negedge clk);
        clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        chk("R5 serial crc zero after mid-shift clear", crc_s, 0);
        chk("R5 serial ready after mid-shift clear", ready_s, 1);
        repeat (16) @(negedge clk);
        chk("R5 serial stays zero after aborted word", crc_s, 0);
        chk("R5 serial no done after aborted word", done_s, 0);

        // R7: parallel back-to-back words
        do_clear();
        @(negedge clk); word = 16'($urandom); valid_p = 1'b1;
        for (int k = 0; k < 32; k++) begin
            exp_crc = model(exp_crc, word);
            @(negedge clk);
            chk("R7 parallel back-to-back crc", crc_p, exp_crc);
            chk("R3 parallel done on last only", done_p, (k == 31));
            word = 16'($urandom);
            if (k == 31) valid_p = 1'b0;
        end
        @(negedge clk);
        chk("R4 parallel held after back-to-back", crc_p, exp_crc);
        chk("R3 parallel done cleared", done_p, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule